// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block runs once after reset and fills a bank of configuration registers from a small serial EEPROM. It first checks whether a device is fitted by looking at the serial data-in line. If a device is present, it reads one 16-bit word at a time over a three-wire serial link with a chip select, clock and data out, and data coming back on data in. It then walks a linked configuration block stored in the device. The block opens with a header word, carries a chain of register groups and closes with a checksum word.

Register values are held in a staging store while the block is parsed. They go out on a one-write-per-cycle register port only when the whole block has arrived intact. If there is no device, the device is blank, the checksum is wrong or the chain is malformed, no register is written and the defaults stay in force. Three flags report the result: finished, accepted, and rejected.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: In the first cycle after reset the block samples `ee_sdi_i`. If it is low, the block raises `done_o` with `ok_o` and `err_o` low, never asserts `ee_cs_o` and issues no register write.
- R2: Each word read holds `ee_cs_o` high for 27 serial clock rises. At rises 1 to 11, `ee_sdo_o` carries 1, 1, 0 and then the 8-bit word address MSB first. At rises 12 to 27 it is low, and the 16 data bits are sampled from `ee_sdi_i` MSB first. The device changes `ee_sdi_i` after each falling clock edge.
- R3: `ee_sck_o` is high only while `ee_cs_o` is high. Within a frame, consecutive rising edges are exactly 2*HALF_CYC system clocks apart.
- R4: The first word read is at address 0, and every later read uses the previous address plus one.
- R5: A header of 16'hFFFF ends the load after that single read, with `done_o` high, `ok_o` and `err_o` low, and no register write.
- R6: Bits 7:0 of the header give the number of body bytes that follow it. The body is followed by exactly one checksum word. An odd byte count ends the load after the header with `err_o` set.
- R7: A body starts with a group header. Bits 15:12 hold the word count minus one and bits 11:0 hold the target register address. The data words that follow go to that address and the consecutive addresses after it.
- R8: If the 8-bit sum of the high and low bytes of every word read (header, body and checksum) is zero, the staged writes are issued on `cfg_we_o`, one per cycle in the order read. `done_o` and `ok_o` then rise together in the cycle after the last write.
- R9: If the checksum sum is not zero, `done_o` and `err_o` are raised and no register write occurs.
- R10: If a group runs past the end of the body, or more than STAGE_DEPTH data words are staged, the load is rejected with `err_o` and no writes. Exactly STAGE_DEPTH data words are accepted.
- R11: During reset all outputs are low. Once `done_o` is high it stays high, `ok_o` and `err_o` no longer change and are never high together, and no write or chip select follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ee_cs_o | output | 1 | EEPROM chip select, active high |
| ee_sck_o | output | 1 | EEPROM serial clock |
| ee_sdo_o | output | 1 | Serial command/address bits to the EEPROM |
| ee_sdi_i | input | 1 | Serial data from the EEPROM; presence strap at reset |
| cfg_we_o | output | 1 | Register write strobe |
| cfg_addr_o | output | 12 | Register word address |
| cfg_data_o | output | 16 | Register write data |
| done_o | output | 1 | Load finished |
| ok_o | output | 1 | Configuration accepted and written |
| err_o | output | 1 | Configuration rejected |

## Verification
A wrong word address or role counter shows up at the serial pins within one frame of about 27 serial clocks. It appears as an address that does not follow its predecessor, or as a frame count that differs from the length the header implies. A corrupted running sum or staging pointer stays hidden until the checksum word has been parsed. From then on it shows within a few cycles, as the wrong flag or as a write sequence whose addresses, data or length differ from those derived from the image. The bench models the EEPROM behaviourally and recomputes the expected write list from the stored image, so each of these faults is caught at the first port where it appears.

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int HALF_CYC    = 25,
  parameter int STAGE_DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic        ee_cs_o,
  output logic        ee_sck_o,
  output logic        ee_sdo_o,
  input  logic        ee_sdi_i,
  output logic        cfg_we_o,
  output logic [11:0] cfg_addr_o,
  output logic [15:0] cfg_data_o,
  output logic        done_o,
  output logic        ok_o,
  output logic        err_o
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int IW = (STAGE_DEPTH > 1) ? $clog2(STAGE_DEPTH) : 1;
  localparam int CW = $clog2(STAGE_DEPTH + 1);

  typedef enum logic [2:0] {S_DET, S_RD, S_GAP, S_PARSE, S_COMMIT, S_DONE} state_t;
  typedef enum logic [1:0] {R_HDR, R_GRP, R_DAT, R_CSUM} role_t;

  state_t        st_q;
  role_t         role_q;
  logic [HW-1:0] hc_q;
  logic          ph_q;
  logic [4:0]    bc_q;
  logic [15:0]   sh_q;
  logic [7:0]    rd_addr_q;
  logic [7:0]    sum_q;
  logic [6:0]    rem_q;
  logic [3:0]    gl_q;
  logic [11:0]   ga_q;
  logic          bad_q;
  logic [CW-1:0] cnt_q, ci_q;
  logic [11:0]   st_a [STAGE_DEPTH];
  logic [15:0]   st_d [STAGE_DEPTH];

  logic [10:0] cmd;
  logic [7:0]  sum_n;
  logic [6:0]  rem_n;
  logic        half_end, stage_we;

  assign cmd      = {3'b110, rd_addr_q};
  assign ee_sdo_o = ee_cs_o && (bc_q < 5'd11) ? cmd[4'd10 - bc_q[3:0]] : 1'b0;
  assign sum_n    = sum_q + sh_q[15:8] + sh_q[7:0];
  assign rem_n    = rem_q - 7'd1;
  assign half_end = (hc_q == HW'(HALF_CYC - 1));
  assign stage_we = (st_q == S_PARSE) && (role_q == R_DAT) && (cnt_q < CW'(STAGE_DEPTH));

  always_ff @(posedge clk_i) begin
    if (stage_we) begin
      st_a[cnt_q[IW-1:0]] <= ga_q;
      st_d[cnt_q[IW-1:0]] <= sh_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_DET;  role_q <= R_HDR;
      hc_q <= '0;     ph_q <= 1'b0;  bc_q <= '0;  sh_q <= '0;
      rd_addr_q <= '0; sum_q <= '0;  rem_q <= '0;
      gl_q <= '0;     ga_q <= '0;    bad_q <= 1'b0;
      cnt_q <= '0;    ci_q <= '0;
      ee_cs_o <= 1'b0; ee_sck_o <= 1'b0;
      cfg_we_o <= 1'b0; cfg_addr_o <= '0; cfg_data_o <= '0;
      done_o <= 1'b0; ok_o <= 1'b0; err_o <= 1'b0;
    end else begin
      cfg_we_o <= 1'b0;
      case (st_q)
        S_DET: begin
          if (ee_sdi_i) begin
            st_q <= S_RD; ee_cs_o <= 1'b1;
            hc_q <= '0; ph_q <= 1'b0; bc_q <= '0;
          end else begin
            st_q <= S_DONE; done_o <= 1'b1;
          end
        end
        S_RD: begin
          if (!half_end) hc_q <= hc_q + 1'b1;
          else begin
            hc_q <= '0;
            if (!ph_q) begin
              ee_sck_o <= 1'b1; ph_q <= 1'b1;
              if (bc_q >= 5'd11) sh_q <= {sh_q[14:0], ee_sdi_i};
            end else begin
              ee_sck_o <= 1'b0; ph_q <= 1'b0;
              if (bc_q == 5'd26) begin
                ee_cs_o <= 1'b0; st_q <= S_GAP;
              end else bc_q <= bc_q + 5'd1;
            end
          end
        end
        S_GAP: begin
          if (!half_end) hc_q <= hc_q + 1'b1;
          else begin
            hc_q <= '0; st_q <= S_PARSE;
          end
        end
        S_PARSE: begin
          rd_addr_q <= rd_addr_q + 8'd1;
          sum_q     <= sum_n;
          st_q      <= S_RD;
          ee_cs_o   <= 1'b1;
          bc_q      <= '0;
          case (role_q)
            R_HDR: begin
              if (sh_q == 16'hFFFF) begin
                st_q <= S_DONE; ee_cs_o <= 1'b0; done_o <= 1'b1;
              end else if (sh_q[0]) begin
                st_q <= S_DONE; ee_cs_o <= 1'b0; done_o <= 1'b1; err_o <= 1'b1;
              end else begin
                rem_q  <= sh_q[7:1];
                role_q <= (sh_q[7:1] == 7'd0) ? R_CSUM : R_GRP;
              end
            end
            R_GRP: begin
              gl_q  <= sh_q[15:12];
              ga_q  <= sh_q[11:0];
              rem_q <= rem_n;
              if (rem_n == 7'd0) begin
                bad_q <= 1'b1; role_q <= R_CSUM;
              end else role_q <= R_DAT;
            end
            R_DAT: begin
              if (stage_we) cnt_q <= cnt_q + 1'b1;
              else          bad_q <= 1'b1;
              ga_q  <= ga_q + 12'd1;
              gl_q  <= gl_q - 4'd1;
              rem_q <= rem_n;
              if (rem_n == 7'd0) begin
                role_q <= R_CSUM;
                if (gl_q != 4'd0) bad_q <= 1'b1;
              end else if (gl_q == 4'd0) role_q <= R_GRP;
            end
            default: begin
              ee_cs_o <= 1'b0;
              if (sum_n == 8'd0 && !bad_q) begin
                st_q <= S_COMMIT; ci_q <= '0;
              end else begin
                st_q <= S_DONE; done_o <= 1'b1; err_o <= 1'b1;
              end
            end
          endcase
        end
        S_COMMIT: begin
          if (ci_q < cnt_q) begin
            cfg_we_o   <= 1'b1;
            cfg_addr_o <= st_a[ci_q[IW-1:0]];
            cfg_data_o <= st_d[ci_q[IW-1:0]];
            ci_q       <= ci_q + 1'b1;
          end else begin
            st_q <= S_DONE; done_o <= 1'b1; ok_o <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
module eeprom_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sck,
  input logic we,
  input logic done,
  input logic ok,
  input logic err
);
  p_sck_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n) sck |-> cs);
  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(ok) && $stable(err));
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n) !(ok && err));
  p_quiet_done_r11: assert property (@(posedge clk) disable iff (!rst_n) done |-> !cs && !we);
  p_commit_end_r8: assert property (@(posedge clk) disable iff (!rst_n) $fell(we) |-> done && ok);
  p_no_write_rej_r9: assert property (@(posedge clk) disable iff (!rst_n) err |-> !we);
  p_no_write_busy_r2: assert property (@(posedge clk) disable iff (!rst_n) cs |-> !we);
endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk u_chk (
  .clk(clk_i), .rst_n(rst_ni), .cs(ee_cs_o), .sck(ee_sck_o),
  .we(cfg_we_o), .done(done_o), .ok(ok_o), .err(err_o)
);

// File: tb/tb_eeprom_cfg_loader.sv
module tb_eeprom_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int DEPTH      = 16;

  logic clk = 1'b0, rst_n = 1'b0, present = 1'b0, ee_bit = 1'b0;
  logic cs, sck, sdo, sdi, we, done, ok, err;
  logic [11:0] waddr;
  logic [15:0] wdata;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdi = cs ? ee_bit : present;

  eeprom_cfg_loader #(.HALF_CYC(HALF), .STAGE_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ee_cs_o(cs), .ee_sck_o(sck), .ee_sdo_o(sdo),
    .ee_sdi_i(sdi), .cfg_we_o(we), .cfg_addr_o(waddr), .cfg_data_o(wdata),
    .done_o(done), .ok_o(ok), .err_o(err));

  int checks = 0, errors = 0;
  logic [15:0] mem [256];
  logic [27:0] exp_q [$];
  logic exp_ok, exp_err;
  int exp_reads, reads_seen, next_addr, bitcnt, since_rise;
  logic prev_sck;
  logic [10:0] cmd_sh;
  logic [15:0] cur_word;

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // behavioural EEPROM and per-clock comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      bitcnt = 0; reads_seen = 0; next_addr = 0; since_rise = 0; prev_sck = 1'b0;
    end else begin
      since_rise++;
      if (!cs) bitcnt = 0;
      if (sck && !prev_sck) begin
        if (bitcnt >= 1) chk(since_rise == 2*HALF, "R3", "sck period", since_rise, 2*HALF);
        since_rise = 0;
        if (bitcnt < 11) cmd_sh = {cmd_sh[9:0], sdo};
        else chk(sdo == 1'b0, "R2", "sdo idle in data phase", sdo, 0);
        bitcnt++;
        if (bitcnt == 11) begin
          chk(cmd_sh[10:8] == 3'b110, "R2", "read opcode", cmd_sh[10:8], 3'b110);
          chk(cmd_sh[7:0] == next_addr[7:0], "R4", "word address", cmd_sh[7:0], next_addr);
          cur_word = mem[cmd_sh[7:0]];
          next_addr++;
          reads_seen++;
        end
      end
      if (!sck && prev_sck && cs && bitcnt >= 11 && bitcnt < 27)
        ee_bit = cur_word[26 - bitcnt];
      prev_sck = sck;
      if (we) begin
        chk(exp_q.size() != 0, "R8", "unexpected write", {20'd0, waddr}, 0);
        if (exp_q.size() != 0) begin
          chk({waddr, wdata} == exp_q[0], "R7", "write addr/data",
              {4'd0, waddr, wdata}, {4'd0, exp_q[0]});
          void'(exp_q.pop_front());
        end
      end
      if (!done) chk(!ok && !err, "R11", "flags before done", {ok, err}, 0);
    end
  end

  task automatic compute_exp();
    logic [27:0] tmp [$];
    int nb, idx, n, s;
    logic [11:0] a;
    bit bad;
    exp_q.delete(); exp_ok = 0; exp_err = 0; exp_reads = 0;
    if (!present) return;
    exp_reads = 1;
    if (mem[0] == 16'hFFFF) return;
    if (mem[0][0]) begin exp_err = 1; return; end
    nb = mem[0][7:0] / 2;
    bad = 0; idx = 1;
    while (idx <= nb) begin
      n = mem[idx][15:12] + 1; a = mem[idx][11:0]; idx++;
      for (int k = 0; k < n; k++) begin
        if (idx > nb) begin bad = 1; break; end
        if (tmp.size() >= DEPTH) bad = 1;
        else tmp.push_back({a, mem[idx]});
        a++; idx++;
      end
    end
    exp_reads = nb + 2;
    s = 0;
    for (int w = 0; w <= nb + 1; w++) s += mem[w][15:8] + mem[w][7:0];
    if ((s % 256) == 0 && !bad) begin exp_ok = 1; exp_q = tmp; end
    else exp_err = 1;
  endtask

  task automatic seal(input int nb);
    int s = 0;
    for (int w = 0; w <= nb; w++) s += mem[w][15:8] + mem[w][7:0];
    mem[nb + 1] = {8'h00, 8'((256 - (s % 256)) % 256)};
  endtask

  task automatic run(input string req);
    int t = 0;
    rst_n = 1'b0;
    compute_exp();
    repeat (3) @(negedge clk);
    chk(!cs && !sck && !we && !done && !ok && !err, "R11", "reset outputs",
        {cs, sck, we, done, ok, err}, 0);
    rst_n = 1'b1;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    if (!done) chk(0, req, "watchdog", t, 20000);
    repeat (4) @(negedge clk);
    chk(ok == exp_ok, req, "ok flag", ok, exp_ok);
    chk(err == exp_err, req, "err flag", err, exp_err);
    chk(reads_seen == exp_reads, req, "read count", reads_seen, exp_reads);
    chk(exp_q.size() == 0, req, "writes missing", exp_q.size(), 0);
    chk(!cs, req, "chip select idle", cs, 0);
  endtask

  task automatic load_valid();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = 16'h300C;
    mem[1] = 16'h2010; mem[2] = 16'h1234; mem[3] = 16'hBEEF; mem[4] = 16'h00A5;
    mem[5] = 16'h0ABC; mem[6] = 16'h5A5A;
    seal(6);
  endtask

  initial begin
    // R1: no device fitted
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    present = 1'b0; run("R1");
    present = 1'b1;
    // R5: blank device
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    run("R5");
    // R7/R8: two groups, accepted
    load_valid(); run("R8");
    // R9: checksum off by one
    load_valid(); mem[7] = mem[7] + 16'd1; run("R9");
    // R10: group overruns the body
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = 16'h0008; mem[1] = 16'h5020; mem[2] = 16'h1111; mem[3] = 16'h2222;
    mem[4] = 16'h3333; seal(4); run("R10");
    // R6: odd byte count
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = 16'h0007; run("R6");
    // R10: one more word than the staging store holds
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = 16'h0026; mem[1] = 16'hF100;
    for (int i = 0; i < 16; i++) mem[2 + i] = 16'hC000 + 16'(i);
    mem[18] = 16'h0200; mem[19] = 16'h7777; seal(19); run("R10");
    // R10: exactly full staging store
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = 16'h0022; mem[1] = 16'hF300;
    for (int i = 0; i < 16; i++) mem[2 + i] = 16'h9100 + 16'(i * 3);
    seal(17); run("R10");
    // R6: empty body, header and checksum only
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    mem[0] = 16'h1200; seal(0); run("R6");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule